// File: doc/BRIEF.md
# Ping-pong SAR conversion sequencer

This block is the digital controller for a 12-bit successive-approximation converter that has two capacitor DAC arrays. The arrays take turns. While one array samples the next input, the other is digitized one bit at a time. The sequencer does not step from a fast free-running clock. It makes one bit decision each time the comparator raises its ready strobe, so the pace of conversion follows the comparator's own settling. The trial pattern drives the converting array, and the comparator answer decides whether each trial bit stays set. After the last decision the raw 12-bit code is presented with a one-cycle valid pulse. The code is not corrected: missing and wide codes caused by capacitor mismatch pass through unchanged, for calibration further down the chain.

The sequencer is a two-state machine. The states are IDLE (waiting for a start, no array being digitized) and CONV (digitizing). It has three named transitions:
- ACCEPT (IDLE to CONV on a start pulse). This loads the MSB trial and swaps the array roles.
- STEP (CONV to CONV on a ready strobe that is not the last). This settles one bit and raises the next lower one.
- FINISH (CONV to IDLE on the twelfth strobe). This publishes the code.

A start that arrives in CONV does not cause a transition. It only raises the overrun pulse. A new conversion can be accepted in the same cycle as the valid pulse, so the inputs can run back to back. This is what lets a fast comparator sustain 18 million conversions per second.

Top module: `pingpong_sar_seq`

## Requirements
- R1: While the synchronous reset is high, the following outputs are all 0 after the next clock edge: `trial_o`, `smp_sel_o`, `busy_o`, `raw_vld_o` and `overrun_o`.
- R2: A `conv_start_i` pulse seen in IDLE makes the following true after the next edge: `busy_o` is 1 and `trial_o` equals 0x800 (only bit 11 set).
- R3: On each `rdy_i` strobe in CONV, two things happen at once. The bit currently on trial keeps the value of `cmp_hi_i` (1 means keep, 0 means clear). The next lower bit is then set to 1, and the bits above are left unchanged.
- R4: `trial_o` changes only on a ready strobe. Clock cycles in CONV without `rdy_i` leave it unchanged. A `rdy_i` strobe in IDLE has no effect: `trial_o` stays 0 and `busy_o` and `raw_vld_o` stay 0.
- R5: The twelfth strobe of a conversion has three effects after the next edge. `raw_vld_o` is high for exactly one cycle, `busy_o` is 0 and `trial_o` is cleared.
- R6: A `conv_start_i` seen while `busy_o` is 1 has four results. It raises `overrun_o` for exactly one cycle. It leaves `trial_o` and `smp_sel_o` unchanged. The running conversion completes with its correct code.
- R7: `smp_sel_o` names the array that is sampling (0 or 1). It toggles once on each accepted start. While `busy_o` is 1, the other array is the one being digitized.
- R8: `raw_code_o` equals the twelve comparator decisions bit for bit, MSB first, with no correction. This includes the end codes 0x000 and 0xFFF.
- R9: A start given in the same cycle that `raw_vld_o` is high is accepted as a new conversion and does not raise `overrun_o`.
- R10: Raising the reset during a conversion aborts it. After the next edge `busy_o` is 0, `trial_o` is 0 and `smp_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| conv_start_i | input | 1 | Start-of-conversion pulse |
| rdy_i | input | 1 | Comparator ready strobe, one cycle per decision |
| cmp_hi_i | input | 1 | Comparator decision, valid with `rdy_i` |
| trial_o | output | RES_BITS | Trial pattern driving the converting array |
| smp_sel_o | output | 1 | Index of the array currently sampling |
| busy_o | output | 1 | High in CONV |
| raw_code_o | output | RES_BITS | Last uncalibrated code |
| raw_vld_o | output | 1 | One-cycle pulse when `raw_code_o` updates |
| overrun_o | output | 1 | One-cycle pulse for a start refused while busy |

## Verification
The bench builds the block at its default resolution of RES_BITS = 12. With twelve steps, every bit position can be walked from MSB to LSB in a few dozen cycles. The all-zero and all-one end codes, alternating patterns and single-bit codes can then be compared against a behavioural comparator. Gaps of different lengths between ready strobes show that pacing comes only from the strobe. Back-to-back starts, a start in the middle of a conversion and a reset in the middle of a conversion cover the role swap, the overrun path and the abort path.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Sequencer states: IDLE waits for a start, CONV runs bit decisions.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_e;

endpackage

// File: rtl/sar_bit_ptr.sv
// One-hot pointer to the bit on trial; shifts down one place per decision.
module sar_bit_ptr #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step,
    output logic [RES_BITS-1:0] mask,
    output logic                last
);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= MSB_ONLY;
        end else if (step) begin
            mask_q <= mask_q >> 1;
        end
    end

    assign mask = mask_q;
    assign last = mask_q[0];
endmodule

// File: rtl/sar_trial_reg.sv
// Trial register: per-bit update selected by the position of the pointer.
module sar_trial_reg #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                load,
    input  logic                step,
    input  logic                cmp_hi,
    input  logic [RES_BITS-1:0] mask,
    output logic [RES_BITS-1:0] trial
);
    logic [RES_BITS-1:0] trial_q;

    for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
        if (i == RES_BITS - 1) begin : g_top
            // MSB: set on load, decided on the first step only.
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    trial_q[i] <= 1'b0;
                end else if (load) begin
                    trial_q[i] <= 1'b1;
                end else if (step && mask[i]) begin
                    trial_q[i] <= cmp_hi;
                end
            end
        end else begin : g_low
            // Lower bits: raised when the bit above is decided, then decided.
            always_ff @(posedge clk) begin
                if (rst || clear || load) begin
                    trial_q[i] <= 1'b0;
                end else if (step) begin
                    if (mask[i]) begin
                        trial_q[i] <= cmp_hi;
                    end else if (mask[i+1]) begin
                        trial_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    assign trial = trial_q;
endmodule

// File: rtl/pingpong_sar_seq.sv
module pingpong_sar_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_start_i,
    input  logic                rdy_i,
    input  logic                cmp_hi_i,
    output logic [RES_BITS-1:0] trial_o,
    output logic                smp_sel_o,
    output logic                busy_o,
    output logic [RES_BITS-1:0] raw_code_o,
    output logic                raw_vld_o,
    output logic                overrun_o
);
    seq_state_e state_q, state_d;

    logic [RES_BITS-1:0] mask;
    logic [RES_BITS-1:0] trial;
    logic                last;
    logic                accept;
    logic                step;
    logic                finish;
    logic                refuse;

    logic [RES_BITS-1:0] code_q;
    logic                vld_q;
    logic                ovr_q;
    logic                sel_q;

    // Named transitions
    assign accept = (state_q == ST_IDLE) && conv_start_i;
    assign step   = (state_q == ST_CONV) && rdy_i;
    assign finish = step && last;
    assign refuse = (state_q == ST_CONV) && conv_start_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_CONV;
            ST_CONV: if (finish) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            vld_q  <= 1'b0;
            ovr_q  <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            vld_q <= finish;
            ovr_q <= refuse;
            if (accept) begin
                sel_q <= ~sel_q;
            end
            if (finish) begin
                code_q <= (trial & ~mask) | ({RES_BITS{cmp_hi_i}} & mask);
            end
        end
    end

    sar_bit_ptr #(.RES_BITS(RES_BITS)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .step (step),
        .mask (mask),
        .last (last)
    );

    sar_trial_reg #(.RES_BITS(RES_BITS)) u_trial (
        .clk    (clk),
        .rst    (rst),
        .clear  (finish),
        .load   (accept),
        .step   (step),
        .cmp_hi (cmp_hi_i),
        .mask   (mask),
        .trial  (trial)
    );

    assign trial_o    = trial;
    assign smp_sel_o  = sel_q;
    assign busy_o     = (state_q == ST_CONV);
    assign raw_code_o = code_q;
    assign raw_vld_o  = vld_q;
    assign overrun_o  = ovr_q;
endmodule

// File: rtl/pingpong_sar_seq_chk.sv
module pingpong_sar_seq_chk #(
    parameter int RES_BITS = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                conv_start_i,
    input logic                rdy_i,
    input logic [RES_BITS-1:0] trial_o,
    input logic                smp_sel_o,
    input logic                busy_o,
    input logic                raw_vld_o,
    input logic                overrun_o
);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && conv_start_i) |=> (busy_o && trial_o == MSB_ONLY));

    // R4
    trial_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !rdy_i) |=> $stable(trial_o));

    // R5
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        raw_vld_o |=> !raw_vld_o);

    // R5
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        raw_vld_o |-> (!busy_o && trial_o == '0));

    // R6
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && conv_start_i) |=> (overrun_o && $stable(smp_sel_o)));

    // R7
    sel_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && conv_start_i) |=> (smp_sel_o != $past(smp_sel_o)));

    // R9
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_vld_o && conv_start_i) |=> (busy_o && !overrun_o));
endmodule

bind pingpong_sar_seq pingpong_sar_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .conv_start_i (conv_start_i),
    .rdy_i        (rdy_i),
    .trial_o      (trial_o),
    .smp_sel_o    (smp_sel_o),
    .busy_o       (busy_o),
    .raw_vld_o    (raw_vld_o),
    .overrun_o    (overrun_o)
);

// File: tb/pingpong_sar_seq_tb.sv
module pingpong_sar_seq_tb;
    localparam int N = 12;

    typedef struct packed {
        logic [N-1:0] vin;
        logic [N-1:0] exp_code;
        logic [3:0]   gap;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{12'h000, 12'h000, 4'd0},
        '{12'hFFF, 12'hFFF, 4'd0},
        '{12'h800, 12'h800, 4'd1},
        '{12'h7FF, 12'h7FF, 4'd2},
        '{12'h555, 12'h555, 4'd0},
        '{12'hAAA, 12'hAAA, 4'd3},
        '{12'h001, 12'h001, 4'd1},
        '{12'h3C5, 12'h3C5, 4'd0}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         conv_start_i;
    logic         rdy_i;
    logic         cmp_hi_i;
    logic [N-1:0] trial_o;
    logic         smp_sel_o;
    logic         busy_o;
    logic [N-1:0] raw_code_o;
    logic         raw_vld_o;
    logic         overrun_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic exp_sel;

    always #4 clk = ~clk;

    pingpong_sar_seq #(.RES_BITS(N)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .conv_start_i (conv_start_i),
        .rdy_i        (rdy_i),
        .cmp_hi_i     (cmp_hi_i),
        .trial_o      (trial_o),
        .smp_sel_o    (smp_sel_o),
        .busy_o       (busy_o),
        .raw_code_o   (raw_code_o),
        .raw_vld_o    (raw_vld_o),
        .overrun_o    (overrun_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected trial after k+1 decisions (k < N-1): decided top bits, next bit raised.
    function automatic logic [N-1:0] exp_trial(input logic [N-1:0] vin, input int k);
        logic [N-1:0] hi;
        hi = ~((12'd1 << (N - 1 - k)) - 12'd1);
        return (vin & hi) | (12'd1 << (N - 2 - k));
    endfunction

    task automatic start_conv();
        conv_start_i = 1'b1;
        @(negedge clk);
        conv_start_i = 1'b0;
        exp_sel = ~exp_sel;
        chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        chk(trial_o == 12'h800, "R2", "msb trial", trial_o, 12'h800);
        chk(smp_sel_o == exp_sel, "R7", "array swap", smp_sel_o, exp_sel);
        chk(overrun_o == 1'b0, "R9", "no overrun on accepted start", overrun_o, 0);
        chk(raw_vld_o == 1'b0, "R5", "valid lasts one cycle", raw_vld_o, 0);
    endtask

    task automatic do_step(input logic [N-1:0] vin, input int k);
        rdy_i    = 1'b1;
        cmp_hi_i = (vin >= trial_o);
        @(negedge clk);
        rdy_i    = 1'b0;
        cmp_hi_i = 1'b0;
        if (k < N - 1)
            chk(trial_o == exp_trial(vin, k), "R3", "trial after decision",
                trial_o, exp_trial(vin, k));
    endtask

    task automatic convert(input vec_t v);
        logic [N-1:0] held;
        start_conv();
        for (int k = 0; k < N; k++) begin
            held = trial_o;
            for (int g = 0; g < int'(v.gap); g++) @(negedge clk);
            if (v.gap != 0)
                chk(trial_o == held, "R4", "trial held without strobe", trial_o, held);
            do_step(v.vin, k);
        end
        chk(raw_vld_o == 1'b1, "R5", "valid pulse", raw_vld_o, 1);
        chk(busy_o == 1'b0 && trial_o == '0, "R5", "idle after last", {busy_o, trial_o}, 0);
        chk(raw_code_o == v.exp_code, "R8", "raw code", raw_code_o, v.exp_code);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] held;
        rst = 1'b1;
        conv_start_i = 1'b0;
        rdy_i = 1'b0;
        cmp_hi_i = 1'b0;
        exp_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk({trial_o, smp_sel_o, busy_o, raw_vld_o, overrun_o} == '0, "R1",
            "reset state", {trial_o, smp_sel_o, busy_o, raw_vld_o, overrun_o}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R4: strobe in IDLE is ignored
        rdy_i = 1'b1;
        cmp_hi_i = 1'b1;
        @(negedge clk);
        rdy_i = 1'b0;
        cmp_hi_i = 1'b0;
        chk(trial_o == '0 && !busy_o && !raw_vld_o, "R4", "idle strobe ignored",
            {busy_o, raw_vld_o, trial_o}, 0);

        // Vector table, run back to back (R9 checked at each start)
        for (int i = 0; i < 8; i++) convert(VEC[i]);
        @(negedge clk);

        // R6: start while busy
        start_conv();
        for (int k = 0; k < 3; k++) do_step(12'h123, k);
        held = trial_o;
        conv_start_i = 1'b1;
        @(negedge clk);
        conv_start_i = 1'b0;
        chk(overrun_o == 1'b1, "R6", "overrun raised", overrun_o, 1);
        chk(trial_o == held, "R6", "trial untouched", trial_o, held);
        chk(smp_sel_o == exp_sel, "R6", "select untouched", smp_sel_o, exp_sel);
        @(negedge clk);
        chk(overrun_o == 1'b0, "R6", "overrun one cycle", overrun_o, 0);
        for (int k = 3; k < N; k++) do_step(12'h123, k);
        chk(raw_vld_o && raw_code_o == 12'h123, "R6", "conversion completes",
            raw_code_o, 12'h123);
        @(negedge clk);

        // R10: reset aborts a conversion
        start_conv();
        do_step(12'h9A4, 0);
        do_step(12'h9A4, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_sel = 1'b0;
        chk(!busy_o && trial_o == '0 && !smp_sel_o, "R10", "abort on reset",
            {busy_o, smp_sel_o, trial_o}, 0);
        @(negedge clk);

        // Conversion after abort starts from array 0 sampling state
        convert('{12'h9A4, 12'h9A4, 4'd0});

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule